// File: doc/BRIEF.md
# Gated Event Counter with Selectable Gate Source

This block is a 16-bit event counter that advances on clock-enable ticks only while its gate is active. The gate comes from one of four places, picked by a 2-bit select input: an external gate pin, a one-tick pulse from a built-in 8-bit period timer, or one of two comparator level inputs. A single polarity bit then decides whether a high or a low level on the chosen source opens the gate.

The period timer counts ticks up to a programmable period value and then restarts from zero, emitting a one-tick pulse as it restarts. With that pulse as the gate, the polarity bit picks between two behaviours. One is a single count per timer period. The other is a count on every tick except the pulse tick. The external pin is asynchronous and passes through a two-flop synchronizer. The comparator inputs are taken as already synchronous to the clock.

Top module: `gated_event_counter`

## Requirements
- R1: Gate select encoding: 2'b00 picks the synchronized external pin, 2'b01 the period-timer pulse, 2'b10 comparator A, 2'b11 comparator B. A change of select takes effect on the next tick.
- R2: With polarity 1 a high source level enables counting. With polarity 0 a low source level enables counting. This applies to every source.
- R3: The period timer advances by one on each tick. On a tick where it equals the period value it returns to 0 and raises its pulse, and the pulse holds for exactly one tick interval.
- R4: Pulse source with polarity 1 and period P: the counter advances once per P+1 ticks, on the tick after each match. From reset with P=3, 20 ticks give a count of 4.
- R5: Pulse source with polarity 0 and period P: the counter advances on every tick except the pulse tick. From reset with P=3, 20 ticks give a count of 16.
- R6: Counter and period timer change only on cycles where the tick input is high. Cycles with tick low leave the count unchanged.
- R7: The counter is 16 bits wide, moves by at most 1 per tick, and wraps from 0xFFFF to 0x0000.
- R8: A period value of 0 makes the pulse high on every tick after the first one. From reset, 10 ticks give a count of 9 with polarity 1 and a count of 1 with polarity 0.
- R9: The external pin passes through two flops. With tick held high, a pin change is first counted on the third rising clock edge after the change.
- R10: Synchronous reset clears the counter, the period timer, its pulse and the synchronizer flops. The count output reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Clock enable, one instruction cycle |
| gate_pin_i | input | 1 | Asynchronous external gate pin |
| cmp_a_i | input | 1 | Comparator A output level (synchronous) |
| cmp_b_i | input | 1 | Comparator B output level (synchronous) |
| gate_sel_i | input | 2 | Gate source select |
| gate_pol_i | input | 1 | Gate polarity, 1 = high-active |
| period_i | input | 8 | Period timer match value |
| count_o | output | 16 | Counter value (registered) |

## Verification
The assertions assume that reset is asserted from the very first clock. They also assume that the comparator levels and configuration fields are synchronous to the clock, since only the external pin is synchronized inside the block. The bench asserts reset from time zero. It changes every input only on falling clock edges, so the comparators and configuration never change near a rising edge. After a pin change it waits several tick-free cycles, so the synchronizer has settled before any counting window opens. The only exception is the one directed test that measures the synchronizer latency.

// File: rtl/gcnt_pkg.sv
package gcnt_pkg;
  typedef enum logic [1:0] {
    GSRC_PIN   = 2'b00,
    GSRC_MATCH = 2'b01,
    GSRC_CMP_A = 2'b10,
    GSRC_CMP_B = 2'b11
  } gate_src_e;
endpackage

// File: rtl/gcnt_sync.sv
module gcnt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];

  // R10
  sync_clear_chk: assert property (@(posedge clk) rst |=> (chain_q == '0));
endmodule

// File: rtl/gcnt_period_timer.sv
module gcnt_period_timer #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [PER_W-1:0] period_i,
  output logic             pulse_o
);
  logic [PER_W-1:0] cnt_q;
  logic             pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (tick_i) begin
      if (cnt_q == period_i) begin
        cnt_q   <= '0;
        pulse_q <= 1'b1;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
        pulse_q <= 1'b0;
      end
    end
  end

  assign pulse_o = pulse_q;

  // R3
  pulse_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(pulse_q));
  // R3
  pulse_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> (cnt_q == '0));
endmodule

// File: rtl/gcnt_gate_mux.sv
module gcnt_gate_mux
  import gcnt_pkg::*;
(
  input  logic [1:0] sel_i,
  input  logic       pol_i,
  input  logic       pin_i,
  input  logic       match_i,
  input  logic       cmp_a_i,
  input  logic       cmp_b_i,
  output logic       gate_o
);
  logic src;

  always_comb begin
    unique case (gate_src_e'(sel_i))
      GSRC_PIN:   src = pin_i;
      GSRC_MATCH: src = match_i;
      GSRC_CMP_A: src = cmp_a_i;
      default:    src = cmp_b_i;
    endcase
  end

  assign gate_o = pol_i ? src : ~src;
endmodule

// File: rtl/gated_event_counter.sv
module gated_event_counter #(
  parameter int CNT_W       = 16,
  parameter int PER_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             gate_pin_i,
  input  logic             cmp_a_i,
  input  logic             cmp_b_i,
  input  logic [1:0]       gate_sel_i,
  input  logic             gate_pol_i,
  input  logic [PER_W-1:0] period_i,
  output logic [CNT_W-1:0] count_o
);
  logic pin_sync;
  logic match_pulse;
  logic gate_en;
  logic [CNT_W-1:0] count_q;

  gcnt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(gate_pin_i), .sync_o(pin_sync)
  );

  gcnt_period_timer #(.PER_W(PER_W)) u_timer (
    .clk(clk), .rst(rst), .tick_i(tick_i), .period_i(period_i),
    .pulse_o(match_pulse)
  );

  gcnt_gate_mux u_mux (
    .sel_i(gate_sel_i), .pol_i(gate_pol_i), .pin_i(pin_sync),
    .match_i(match_pulse), .cmp_a_i(cmp_a_i), .cmp_b_i(cmp_b_i),
    .gate_o(gate_en)
  );

  always_ff @(posedge clk) begin
    if (rst)                    count_q <= '0;
    else if (tick_i && gate_en) count_q <= count_q + 1'b1;
  end

  assign count_o = count_q;

  // R6
  count_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(count_q));
  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    tick_i |=> (count_q == $past(count_q) || count_q == $past(count_q) + 1'b1));
  // R10
  count_clear_chk: assert property (@(posedge clk) rst |=> (count_q == '0));
endmodule

// File: tb/gated_event_counter_tb.sv
module gated_event_counter_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, pin = 1'b0, ca = 1'b0, cb = 1'b0, pol = 1'b1;
  logic [1:0]  sel = 2'b00;
  logic [7:0]  period = 8'd5;
  logic [15:0] count;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  gated_event_counter dut_i (
    .clk(clk), .rst(rst), .tick_i(tick), .gate_pin_i(pin), .cmp_a_i(ca),
    .cmp_b_i(cb), .gate_sel_i(sel), .gate_pol_i(pol), .period_i(period),
    .count_o(count)
  );

  // {sel[2], pol, pin, cmp_a, cmp_b, ticks[8], expected delta[8]}  (R1, R2)
  localparam logic [21:0] VEC [10] = '{
    {2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 8'd5, 8'd5},
    {2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 8'd5, 8'd0},
    {2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'd4, 8'd4},
    {2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 8'd4, 8'd0},
    {2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 8'd6, 8'd6},
    {2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 8'd6, 8'd0},
    {2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 8'd3, 8'd3},
    {2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 8'd7, 8'd7},
    {2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 8'd3, 8'd0},
    {2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 8'd2, 8'd2}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_ticks(input int n);
    tick = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; tick = 1'b0;
    idle(2);
    rst = 1'b0;
  endtask

  initial begin
    #3_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] base;
    @(negedge clk);
    do_reset();
    check("R10 reset value", count, 16'h0000);

    // Table walk: R1 R2
    for (int v = 0; v < 10; v++) begin
      {sel, pol, pin, ca, cb} = VEC[v][21:16];
      idle(4);
      base = count;
      run_ticks(int'(VEC[v][15:8]));
      check($sformatf("R1/R2 vector %0d", v), count - base, 16'(VEC[v][7:0]));
    end

    // R6: gate open, no ticks
    sel = 2'b10; pol = 1'b1; ca = 1'b1;
    base = count;
    idle(10);
    check("R6 no tick no count", count, base);

    // R4: match pulse polarity 1, period 3
    sel = 2'b01; pol = 1'b1; period = 8'd3;
    do_reset();
    run_ticks(20);
    check("R4 one count per period", count, 16'd4);

    // R5: polarity 0
    pol = 1'b0;
    do_reset();
    run_ticks(20);
    check("R5 all but pulse tick", count, 16'd16);

    // R3: pulse lasts one tick interval, hold during idle
    pol = 1'b1;
    do_reset();
    run_ticks(4);               // match on tick 4, pulse now high
    idle(5);                    // pulse must hold without ticks
    run_ticks(1);
    check("R3 pulse held over idle", count, 16'd1);
    run_ticks(1);
    check("R3 pulse one tick wide", count, 16'd1);

    // R8: period 0
    period = 8'd0; pol = 1'b1;
    do_reset();
    run_ticks(10);
    check("R8 period0 pol1", count, 16'd9);
    pol = 1'b0;
    do_reset();
    run_ticks(10);
    check("R8 period0 pol0", count, 16'd1);

    // R9: synchronizer latency
    sel = 2'b00; pol = 1'b1; pin = 1'b0;
    do_reset();
    idle(4);
    tick = 1'b1;
    pin = 1'b1;
    idle(2);
    check("R9 no count before third edge", count, 16'd0);
    idle(1);
    tick = 1'b0;
    check("R9 count on third edge", count, 16'd1);

    // R10: mid-run reset clears
    run_ticks(5);
    do_reset();
    check("R10 reset mid-run", count, 16'd0);

    // R7: wrap
    sel = 2'b10; pol = 1'b1; ca = 1'b1;
    do_reset();
    run_ticks(65535);
    check("R7 reaches max", count, 16'hFFFF);
    run_ticks(1);
    check("R7 wraps to zero", count, 16'h0000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule